// File: doc/BRIEF.md
# Datagram Packet Transmitter Node

This block turns a single message into a framed stream of 8-bit words for one subnet link. A message is a 28-bit destination address, a 28-bit source address and a payload whose width is a parameter. A one-cycle transmit-enable request starts a packet. The block captures all three inputs in the cycle it accepts the request. It then puts out a start code and the four destination groups, followed by the four source groups. After those come the payload groups and a stop code. Every address and payload word carries seven data bits in its low bits, with the top bit cleared.

Addresses leave most significant group first. The payload leaves least significant group first, and the final payload group is padded with zeros above the payload width. While no packet is being sent, the line carries the idle code. A busy flag covers the whole packet. Requests that arrive while busy is high are dropped.

The output word is a stream that the receiving side can pause. The line always carries a meaningful word, either idle or packet content, so it has no separate valid flag. A word counts as consumed at a rising clock edge where `out_ready` is high. While `out_ready` is low, the current word and the busy flag hold, and the packet resumes where it stopped. The transmit-enable request is a plain control pin and does not depend on `out_ready`.

Top module: `txn_tx_node`

## Requirements
- R1: While busy is low, out_word is the idle code 0x00.
- R2: A packet has exactly 10 + ceil(PAYLOAD_W/7) words, in this order: start code 0x01, four destination words, four source words, the payload words, then stop code 0x40.
- R3: Each address is sent as four 7-bit groups, highest first: bits 27..21, then 20..14, then 13..7, then 6..0.
- R4: Payload groups go out lowest first (bits 6..0, then 13..7, and so on). Bits of the last group that lie above PAYLOAD_W-1 are sent as 0.
- R5: Every address and payload word has its data in bits 6..0, and its bit 7 is 0.
- R6: A request is accepted at a rising edge where tx_en is high and busy is low. Address and payload inputs are captured at that edge, and later changes to them do not alter the packet.
- R7: A tx_en pulse while busy is high has no effect: the packet in progress continues unchanged and no extra packet follows.
- R8: Busy goes high in the cycle after acceptance, with out_word equal to the start code. Busy goes low after the stop word is consumed. Consecutive packets are therefore separated by at least one idle word.
- R9: While busy is high and out_ready is low, out_word and busy keep their values at the next edge. Each edge with out_ready high advances the packet by one word.
- R10: During and straight after reset, busy is low and out_word is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Request to send one packet |
| dest_addr | input | ADDR_W (28) | Destination address, captured on acceptance |
| src_addr | input | ADDR_W (28) | Source address, captured on acceptance |
| payload | input | PAYLOAD_W | Message payload, captured on acceptance |
| out_ready | input | 1 | Downstream accepts the current word at this edge |
| out_word | output | 8 | Line word: idle, start, data or stop code |
| busy | output | 1 | A packet is being sent |

## Verification
The bound assertions check on every cycle that the line is idle whenever busy is low and that bit 7 is clear. They also check that every packet opens with the start code and closes only after a consumed stop code. A further cycle-by-cycle check is that a stalled word holds steady, and that a request during a packet does not end it. Only the bench scenarios can show the group order of addresses and payload, the zero padding of the top payload group, and that inputs changed after acceptance are not sent. The same holds for the absence of a packet from a dropped request: the scoreboard compares every consumed word against packets computed from the requirements, with and without back-pressure.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int WORD_W   = 8;
  localparam int GRP_W    = 7;
  localparam logic [WORD_W-1:0] CODE_IDLE  = 8'h00;
  localparam logic [WORD_W-1:0] CODE_START = 8'h01;
  localparam logic [WORD_W-1:0] CODE_STOP  = 8'h40;

  function automatic int grp_count(input int width);
    return (width + GRP_W - 1) / GRP_W;
  endfunction
endpackage

// File: rtl/txn_sequencer.sv
module txn_sequencer #(
  parameter int TOTAL_WORDS = 13,
  localparam int IDX_W = $clog2(TOTAL_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             out_ready,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  // a request is taken only while the line is free (R6, R7)
  assign accept = tx_en & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (tx_en) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (out_ready) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txn_capture.sv
module txn_capture #(
  parameter int ADDR_W    = 28,
  parameter int PAYLOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    dest_addr,
  input  logic [ADDR_W-1:0]    src_addr,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [ADDR_W-1:0]    dest_q,
  output logic [ADDR_W-1:0]    src_q,
  output logic [PAYLOAD_W-1:0] pay_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      src_q  <= '0;
      pay_q  <= '0;
    end else if (accept) begin
      dest_q <= dest_addr;
      src_q  <= src_addr;
      pay_q  <= payload;
    end
  end
endmodule

// File: rtl/txn_word_mux.sv
module txn_word_mux
  import txn_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int PAYLOAD_W = 20,
  localparam int ADDR_GRPS = grp_count(ADDR_W),
  localparam int PAY_GRPS  = grp_count(PAYLOAD_W),
  localparam int TOTAL     = 2 + 2*ADDR_GRPS + PAY_GRPS,
  localparam int IDX_W     = $clog2(TOTAL)
) (
  input  logic                 busy,
  input  logic [IDX_W-1:0]     idx,
  input  logic [ADDR_W-1:0]    dest_q,
  input  logic [ADDR_W-1:0]    src_q,
  input  logic [PAYLOAD_W-1:0] pay_q,
  output logic [WORD_W-1:0]    word
);
  localparam int SRC_BASE = 1 + ADDR_GRPS;
  localparam int PAY_BASE = 1 + 2*ADDR_GRPS;
  localparam int STOP_IDX = TOTAL - 1;

  logic [ADDR_GRPS*GRP_W-1:0] dest_pad, src_pad;
  logic [PAY_GRPS*GRP_W-1:0]  pay_pad;
  logic [GRP_W-1:0] dest_grp [ADDR_GRPS];
  logic [GRP_W-1:0] src_grp  [ADDR_GRPS];
  logic [GRP_W-1:0] pay_grp  [PAY_GRPS];

  always_comb begin
    dest_pad = '0;
    src_pad  = '0;
    pay_pad  = '0;
    dest_pad[ADDR_W-1:0]  = dest_q;
    src_pad[ADDR_W-1:0]   = src_q;
    pay_pad[PAYLOAD_W-1:0] = pay_q;
  end

  // address groups: index 0 is the most significant group
  for (genvar g = 0; g < ADDR_GRPS; g++) begin : g_addr
    assign dest_grp[g] = dest_pad[(ADDR_GRPS-1-g)*GRP_W +: GRP_W];
    assign src_grp[g]  = src_pad[(ADDR_GRPS-1-g)*GRP_W +: GRP_W];
  end

  // payload groups: index 0 is the least significant group
  for (genvar k = 0; k < PAY_GRPS; k++) begin : g_pay
    assign pay_grp[k] = pay_pad[k*GRP_W +: GRP_W];
  end

  always_comb begin
    word = CODE_IDLE;
    if (busy) begin
      if (int'(idx) == 0) word = CODE_START;
      if (int'(idx) == STOP_IDX) word = CODE_STOP;
      for (int g = 0; g < ADDR_GRPS; g++) begin
        if (int'(idx) == 1 + g)        word = {1'b0, dest_grp[g]};
        if (int'(idx) == SRC_BASE + g) word = {1'b0, src_grp[g]};
      end
      for (int k = 0; k < PAY_GRPS; k++) begin
        if (int'(idx) == PAY_BASE + k) word = {1'b0, pay_grp[k]};
      end
    end
  end
endmodule

// File: rtl/txn_tx_node.sv
module txn_tx_node
  import txn_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int PAYLOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic [ADDR_W-1:0]    dest_addr,
  input  logic [ADDR_W-1:0]    src_addr,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic                 out_ready,
  output logic [7:0]           out_word,
  output logic                 busy
);
  localparam int ADDR_GRPS = grp_count(ADDR_W);
  localparam int PAY_GRPS  = grp_count(PAYLOAD_W);
  localparam int TOTAL     = 2 + 2*ADDR_GRPS + PAY_GRPS;
  localparam int IDX_W     = $clog2(TOTAL);

  logic                 accept;
  logic [IDX_W-1:0]     idx;
  logic [ADDR_W-1:0]    dest_q, src_q;
  logic [PAYLOAD_W-1:0] pay_q;

  txn_sequencer #(.TOTAL_WORDS(TOTAL)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .out_ready(out_ready),
    .accept(accept), .busy(busy), .idx(idx)
  );

  txn_capture #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .dest_addr(dest_addr), .src_addr(src_addr), .payload(payload),
    .dest_q(dest_q), .src_q(src_q), .pay_q(pay_q)
  );

  txn_word_mux #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_mux (
    .busy(busy), .idx(idx), .dest_q(dest_q), .src_q(src_q),
    .pay_q(pay_q), .word(out_word)
  );
endmodule

// File: rtl/txn_tx_checker.sv
module txn_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       out_ready,
  input logic       busy,
  input logic [7:0] out_word
);
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> out_word == 8'h00);

  assert_start_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> out_word == 8'h01);

  assert_stop_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(out_word) == 8'h40 && $past(out_ready)));

  assert_top_bit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[7] == 1'b0);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(out_word));

  assert_busy_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tx_en && out_word != 8'h40 |=> busy);
endmodule

bind txn_tx_node txn_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .out_ready(out_ready),
  .busy(busy), .out_word(out_word)
);

// File: tb/txn_tx_node_test.sv
`timescale 1ns/1ps
module txn_tx_node_test;
  localparam int AW = 28;
  localparam int PW = 20;
  localparam int PG = (PW + 6) / 7;
  localparam int NW = 10 + PG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic [AW-1:0] dest_addr = '0;
  logic [AW-1:0] src_addr = '0;
  logic [PW-1:0] payload = '0;
  logic          out_ready = 1'b1;
  logic [7:0]    out_word;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  txn_tx_node #(.ADDR_W(AW), .PAYLOAD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dest_addr(dest_addr),
    .src_addr(src_addr), .payload(payload), .out_ready(out_ready),
    .out_word(out_word), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // expected words derived from R2, R3, R4
  task automatic push_packet(input logic [AW-1:0] d, input logic [AW-1:0] s,
                             input logic [PW-1:0] p);
    logic [PG*7-1:0] pp;
    pp = '0;
    pp[PW-1:0] = p;
    exp_q.push_back(8'h01);
    for (int g = 0; g < 4; g++) exp_q.push_back({1'b0, d[27-7*g -: 7]});
    for (int g = 0; g < 4; g++) exp_q.push_back({1'b0, s[27-7*g -: 7]});
    for (int k = 0; k < PG; k++) exp_q.push_back({1'b0, pp[7*k +: 7]});
    exp_q.push_back(8'h40);
  endtask

  task automatic send(input logic [AW-1:0] d, input logic [AW-1:0] s,
                      input logic [PW-1:0] p);
    @(negedge clk);
    while (busy) @(negedge clk);
    tx_en = 1'b1;
    dest_addr = d;
    src_addr = s;
    payload = p;
    push_packet(d, s, p);
    @(posedge clk);
    #1;
    tx_en = 1'b0;
    // R6: scramble inputs after acceptance
    dest_addr = AW'($urandom);
    src_addr = AW'($urandom);
    payload = PW'($urandom);
  endtask

  // R7: requests during a packet must vanish
  task automatic poke_while_busy();
    @(negedge clk);
    tx_en = 1'b1;
    dest_addr = 28'hABCDEF1;
    payload = 20'h12345;
    repeat (2) @(negedge clk);
    tx_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  int  pos = 0;
  bit  hold_chk = 1'b0;
  bit  stop_seen = 1'b0;
  logic [7:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_chk) begin
        check(busy && out_word == held, "R9 stalled word held", int'(out_word), int'(held));
        hold_chk = 1'b0;
      end
      if (stop_seen) begin
        check(!busy, "R8 busy low after stop", int'(busy), 0);
        stop_seen = 1'b0;
      end
      if (!busy) begin
        check(out_word == 8'h00, "R1 idle code", int'(out_word), 0);
      end else if (out_ready) begin
        logic [7:0] e;
        string tag;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected packet word", int'(out_word), 0);
        end else begin
          e = exp_q.pop_front();
          if (pos == 0 || pos == NW-1) tag = "R2 framing word";
          else if (pos <= 8) tag = "R3 address group";
          else tag = "R4 payload group";
          check(out_word == e, tag, int'(out_word), int'(e));
          if (pos != 0 && pos != NW-1)
            check(out_word[7] == 1'b0, "R5 data bit7 clear", int'(out_word[7]), 0);
        end
        pos++;
        if (pos == NW) begin
          pos = 0;
          stop_seen = 1'b1;
        end
      end else begin
        hold_chk = 1'b1;
        held = out_word;
      end
    end
  end

  initial begin
    #(200000.0 * 5.0);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    tx_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    check(out_word == 8'h00, "R10 idle in reset", int'(out_word), 0);
    tx_en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(busy == 1'b0 && out_word == 8'h00, "R10 after reset", int'(out_word), 0);

    send(28'h8102040, 28'h0000001, 20'h00081);
    send(28'hFFFFFFF, 28'h1234567, 20'hFFFFF);
    poke_while_busy();
    send(28'h0000000, 28'hFEDCBA9, 20'h00000);
    send(28'h5A5A5A5, 28'hA5A5A5A, 20'h80001);
    stall_mode = 1'b1;
    send(28'h7654321, 28'h0F0F0F0, 20'h7F3F1);
    poke_while_busy();
    send(28'h1111111, 28'h2222222, 20'hAAAAA);
    send(28'h3C3C3C3, 28'hC3C3C3C, 20'h55555);
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 no extra or missing words", exp_q.size(), 0);
    report();
  end
endmodule